// File: doc/BRIEF.md
# Power Rail Sequencing Controller

This controller switches the enable lines of seven voltage regulators and holds an active-low processor reset. From the off state a push-button press turns on two rails first. The remaining early rails follow once the anchor rail (rail 5) reports power-good for a programmable number of cycles. A reset interval counted in clock ticks then runs before the processor is released. Once running, the host keeps the system alive through a hold pin and uses an enable pin to move between full operation and a light sleep. In light sleep only the always-needed rails stay up.

A small control register offers three bits: a power-down request that drops the system into deep sleep, a plain deep-sleep-ready flag for software, and an override that keeps rail 3 on whatever the enable pin does. In deep sleep only rail 1 runs. A button press clears the power-down request and starts the wake path, which reuses the reset interval but skips the cold-start stagger. Analog regulation, comparators, debouncing and the serial bus are outside the block. Registers are reached through a write strobe with write data and a read-data port.

Top module: `pmic_seq_ctrl`

## Requirements
- R1: After reset every rail enable is low, rst_out_n is low, btn_stat_n is high and reg_rdata reads 0.
- R2: In the off state a button press enables rails 3 and 5 (rail_en = 7'b0010100, bit k is rail k+1) one cycle after the state changes. Rails 1 and 2 stay off until rail5_pg has been high for STAG_CYC consecutive cycles.
- R3: When rails 1 and 2 come on (rail_en = 7'b0010111), rst_out_n stays low for RST_CYC further cycles and then goes high.
- R4: While running, if the hold pin is low and the button is released, the block returns to off and all rails go low.
- R5: While running with hold high, a high enable pin turns on all seven rails. A low enable pin gives light sleep with only rails 1, 2 and 5 on (7'b0010011).
- R6: Register bit 2 (rail-3 keep) keeps rail 3 on in light sleep.
- R7: btn_stat_n goes low one cycle after the button is pressed while running or in light sleep, and is high otherwise.
- R8: Writing 1 to register bit 0 while running or in light sleep enters deep sleep, where only rail 1 is on and rst_out_n is low. Writes to bit 0 in any other state are ignored.
- R9: A button press in deep sleep clears bit 0 and enables rails 1, 3 and 5 (7'b0010101). Once rail5_pg is high, rail 2 is enabled on the next cycle with no stagger, and the reset interval of R3 runs.
- R10: Register bit 1 (deep-sleep-ready) is plain read/write storage that keeps its value through deep sleep and wake.
- R11: If a button press in deep sleep and a register write of 1 to bit 0 fall in the same cycle, the button wins and bit 0 reads 0. Bits 1 and 2 of that write still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn | input | 1 | Debounced push-button level, high while pressed |
| rail5_pg | input | 1 | Power-good flag of rail 5 (at 93% of target) |
| hold | input | 1 | Host keep-alive pin |
| en | input | 1 | Host enable pin for rails 3, 4, 6, 7 |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 3 | Write data: bit0 power-down, bit1 ready flag, bit2 rail-3 keep |
| reg_rdata | output | 3 | Read data, same bit layout |
| rail_en | output | 7 | Regulator enables, bit k drives rail k+1 |
| rst_out_n | output | 1 | Active-low processor reset |
| btn_stat_n | output | 1 | Active-low button interrupt |

## Verification
The button press that wakes the block from deep sleep and a software write that sets the power-down bit both act on bit 0. They can land on the same clock edge. The bench provokes this by raising the button and pulsing a write of 3'b011 in one cycle while in deep sleep. It then expects bit 0 to read 0, the ready flag to read 1, the rail-3 keep to read 0, and the wake rail set to appear on the following edge. A behavioural model compared on every clock also judges any other overlap, such as a press coinciding with a hold drop.

// File: rtl/pmic_seq_pkg.sv
package pmic_seq_pkg;

   localparam int unsigned NUM_RAILS = 7;
   localparam int unsigned REG_W     = 3;

   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_PWRUP  = 3'd1,
      ST_RSTW   = 3'd2,
      ST_ACTIVE = 3'd3,
      ST_SLEEP  = 3'd4,
      ST_DEEP   = 3'd5,
      ST_WAKEW  = 3'd6
   } seq_state_t;

   // rail k+1 drives bit k
   localparam logic [NUM_RAILS-1:0] M_START = 7'b0010100;
   localparam logic [NUM_RAILS-1:0] M_EARLY = 7'b0010111;
   localparam logic [NUM_RAILS-1:0] M_CORE  = 7'b0010011;
   localparam logic [NUM_RAILS-1:0] M_R3    = 7'b0000100;
   localparam logic [NUM_RAILS-1:0] M_HOSTS = 7'b1101000;
   localparam logic [NUM_RAILS-1:0] M_DEEP  = 7'b0000001;
   localparam logic [NUM_RAILS-1:0] M_WAKE  = 7'b0010101;

   function automatic logic [NUM_RAILS-1:0] rail_mask(seq_state_t s, logic keep3, logic en_pin);
      logic [NUM_RAILS-1:0] m;
      case (s)
         ST_PWRUP:  m = M_START;
         ST_RSTW:   m = M_EARLY;
         ST_ACTIVE: m = M_CORE | ((en_pin | keep3) ? M_R3 : '0) | (en_pin ? M_HOSTS : '0);
         ST_SLEEP:  m = M_CORE | (keep3 ? M_R3 : '0);
         ST_DEEP:   m = M_DEEP;
         ST_WAKEW:  m = M_WAKE;
         default:   m = '0;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pmic_seq_timer.sv
module pmic_seq_timer #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          inc,
   output logic [CW-1:0] cnt
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/pmic_seq_regs.sv
module pmic_seq_regs
   import pmic_seq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  seq_state_t       st,
   input  logic             btn,
   output logic             pd_q,
   output logic             rdy_q,
   output logic             keep3_q
);

   logic pd_open;
   assign pd_open = (st == ST_ACTIVE) || (st == ST_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q    <= 1'b0;
         rdy_q   <= 1'b0;
         keep3_q <= 1'b0;
      end else begin
         if (st == ST_DEEP && btn) pd_q <= 1'b0;
         else if (we && pd_open)   pd_q <= wdata[0];
         if (we) begin
            rdy_q   <= wdata[1];
            keep3_q <= wdata[2];
         end
      end
   end

endmodule

// File: rtl/pmic_seq_fsm.sv
module pmic_seq_fsm
   import pmic_seq_pkg::*;
#(
   parameter int unsigned RST_CYC  = 4,
   parameter int unsigned STAG_CYC = 2,
   parameter int unsigned CW       = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          btn,
   input  logic          hold,
   input  logic          en,
   input  logic          pg5,
   input  logic          pd,
   input  logic [CW-1:0] cnt,
   output seq_state_t    st_q,
   output logic          t_clr,
   output logic          t_inc
);

   localparam logic [CW-1:0] RST_LAST  = CW'(RST_CYC - 1);
   localparam logic [CW-1:0] STAG_LAST = CW'(STAG_CYC - 1);

   seq_state_t nxt;
   logic       drop;

   assign drop = !hold && !btn;

   always_comb begin
      nxt = st_q;
      case (st_q)
         ST_OFF:    if (btn) nxt = ST_PWRUP;
         ST_PWRUP:  if (pg5 && cnt == STAG_LAST) nxt = ST_RSTW;
         ST_RSTW:   if (cnt == RST_LAST) nxt = ST_ACTIVE;
         ST_ACTIVE: begin
            if (pd)               nxt = ST_DEEP;
            else if (drop)        nxt = ST_OFF;
            else if (hold && !en) nxt = ST_SLEEP;
         end
         ST_SLEEP: begin
            if (pd)        nxt = ST_DEEP;
            else if (drop) nxt = ST_OFF;
            else if (en)   nxt = ST_ACTIVE;
         end
         ST_DEEP:   if (btn) nxt = ST_WAKEW;
         ST_WAKEW:  if (pg5) nxt = ST_RSTW;
         default:   nxt = ST_OFF;
      endcase
   end

   assign t_clr = (nxt != st_q) || (st_q == ST_PWRUP && !pg5);
   assign t_inc = (st_q == ST_PWRUP) || (st_q == ST_RSTW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_OFF;
      else        st_q <= nxt;
   end

endmodule

// File: rtl/pmic_seq_outs.sv
module pmic_seq_outs
   import pmic_seq_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  seq_state_t           st,
   input  logic                 keep3,
   input  logic                 en,
   input  logic                 btn,
   output logic [NUM_RAILS-1:0] rail_en,
   output logic                 rst_out_n,
   output logic                 btn_stat_n
);

   logic [NUM_RAILS-1:0] want;
   logic                 running;

   assign want    = rail_mask(st, keep3, en);
   assign running = (st == ST_ACTIVE) || (st == ST_SLEEP);

   for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) rail_en[g] <= 1'b0;
         else        rail_en[g] <= want[g];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_out_n  <= 1'b0;
         btn_stat_n <= 1'b1;
      end else begin
         rst_out_n  <= running;
         btn_stat_n <= !(btn && running);
      end
   end

endmodule

// File: rtl/pmic_seq_ctrl.sv
module pmic_seq_ctrl
   import pmic_seq_pkg::*;
#(
   parameter int unsigned RST_CYC  = 52_000_000,
   parameter int unsigned STAG_CYC = 1_600_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 btn,
   input  logic                 rail5_pg,
   input  logic                 hold,
   input  logic                 en,
   input  logic                 reg_we,
   input  logic [REG_W-1:0]     reg_wdata,
   output logic [REG_W-1:0]     reg_rdata,
   output logic [NUM_RAILS-1:0] rail_en,
   output logic                 rst_out_n,
   output logic                 btn_stat_n
);

   localparam int unsigned TMAX = (RST_CYC > STAG_CYC) ? RST_CYC : STAG_CYC;
   localparam int unsigned CW   = $clog2(TMAX + 1);

   if (RST_CYC < 1) begin : g_bad_rst
      $error("RST_CYC must be at least 1");
   end
   if (STAG_CYC < 1) begin : g_bad_stag
      $error("STAG_CYC must be at least 1");
   end

   seq_state_t    state_q;
   logic [CW-1:0] cnt;
   logic          t_clr, t_inc;
   logic          pd_q, rdy_q, keep3_q;

   pmic_seq_timer #(.CW(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc), .cnt(cnt)
   );

   pmic_seq_fsm #(.RST_CYC(RST_CYC), .STAG_CYC(STAG_CYC), .CW(CW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .btn(btn), .hold(hold), .en(en),
      .pg5(rail5_pg), .pd(pd_q), .cnt(cnt),
      .st_q(state_q), .t_clr(t_clr), .t_inc(t_inc)
   );

   pmic_seq_regs u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .wdata(reg_wdata),
      .st(state_q), .btn(btn),
      .pd_q(pd_q), .rdy_q(rdy_q), .keep3_q(keep3_q)
   );

   pmic_seq_outs u_outs (
      .clk(clk), .rst_n(rst_n), .st(state_q), .keep3(keep3_q), .en(en),
      .btn(btn), .rail_en(rail_en), .rst_out_n(rst_out_n),
      .btn_stat_n(btn_stat_n)
   );

   assign reg_rdata = {keep3_q, rdy_q, pd_q};

endmodule

// File: rtl/pmic_seq_chk.sv
module pmic_seq_chk
   import pmic_seq_pkg::*;
(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 btn,
   input seq_state_t           st,
   input logic [NUM_RAILS-1:0] rail_en,
   input logic                 rst_out_n,
   input logic                 btn_stat_n,
   input logic                 pd_bit
);

   // R4
   off_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_OFF |=> rail_en == '0);

   // R8
   deep_one_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_DEEP |=> rail_en == 7'b0000001);

   // R3
   reset_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_ACTIVE && st != ST_SLEEP) |=> !rst_out_n);

   // R7
   btn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !btn |=> btn_stat_n);

   // R9
   wake_clears_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEEP && btn) |=> !pd_bit);

   // R5
   sleep_hosts_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st == ST_SLEEP |=> (rail_en & 7'b1101000) == '0);

endmodule

bind pmic_seq_ctrl pmic_seq_chk u_chk (
   .clk(clk), .rst_n(rst_n), .btn(btn), .st(state_q), .rail_en(rail_en),
   .rst_out_n(rst_out_n), .btn_stat_n(btn_stat_n), .pd_bit(reg_rdata[0])
);

// File: tb/pmic_seq_ctrl_test.sv
module pmic_seq_ctrl_test;

   localparam int RST  = 6;
   localparam int STAG = 3;
   localparam int S_OFF = 0, S_PU = 1, S_RW = 2, S_ACT = 3, S_SLP = 4, S_DS = 5, S_WW = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn = 1'b0, pg5 = 1'b0, hold = 1'b0, en = 1'b0, we = 1'b0;
   logic [2:0] wd = 3'b000;
   logic [2:0] rdata;
   logic [6:0] rails;
   logic rstn_o, bstat_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit live = 1'b0;

   always #2.5 clk = ~clk;

   pmic_seq_ctrl #(.RST_CYC(RST), .STAG_CYC(STAG)) uut (
      .clk(clk), .rst_n(rst_n), .btn(btn), .rail5_pg(pg5), .hold(hold), .en(en),
      .reg_we(we), .reg_wdata(wd), .reg_rdata(rdata), .rail_en(rails),
      .rst_out_n(rstn_o), .btn_stat_n(bstat_n)
   );

   // ---------------- reference model ----------------
   int m_st = S_OFF, m_cnt = 0;
   bit m_pd = 0, m_rdy = 0, m_keep = 0, m_rstn = 0, m_bsn = 1;
   logic [6:0] m_rails = '0;

   function automatic logic [6:0] exp_rails(int s, bit k, bit e);
      logic [6:0] v = '0;
      for (int r = 1; r <= 7; r++) begin
         bit on = 0;
         case (s)
            S_PU:  on = (r == 3 || r == 5);
            S_RW:  on = (r == 1 || r == 2 || r == 3 || r == 5);
            S_ACT: on = (r == 1 || r == 2 || r == 5) || (r == 3 && (e || k))
                        || ((r == 4 || r == 6 || r == 7) && e);
            S_SLP: on = (r == 1 || r == 2 || r == 5) || (r == 3 && k);
            S_DS:  on = (r == 1);
            S_WW:  on = (r == 1 || r == 3 || r == 5);
            default: on = 0;
         endcase
         v[r-1] = on;
      end
      return v;
   endfunction

   function automatic string tag_of(int s);
      case (s)
         S_OFF: return "R1/R4";
         S_PU:  return "R2";
         S_RW:  return "R3";
         S_ACT: return "R5";
         S_SLP: return "R6";
         S_DS:  return "R8";
         default: return "R9";
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_st <= S_OFF; m_cnt <= 0; m_pd <= 0; m_rdy <= 0; m_keep <= 0;
         m_rails <= '0; m_rstn <= 0; m_bsn <= 1;
      end else begin
         bit run;
         run = (m_st == S_ACT || m_st == S_SLP);
         if (we) begin m_rdy <= wd[1]; m_keep <= wd[2]; end
         if (m_st == S_DS && btn) m_pd <= 0;
         else if (we && run)      m_pd <= wd[0];
         m_rails <= exp_rails(m_st, m_keep, en);
         m_rstn  <= run;
         m_bsn   <= !(btn && run);
         case (m_st)
            S_OFF: if (btn) begin m_st <= S_PU; m_cnt <= 0; end
            S_PU: begin
               if (!pg5) m_cnt <= 0;
               else if (m_cnt == STAG - 1) begin m_st <= S_RW; m_cnt <= 0; end
               else m_cnt <= m_cnt + 1;
            end
            S_RW: begin
               if (m_cnt == RST - 1) begin m_st <= S_ACT; m_cnt <= 0; end
               else m_cnt <= m_cnt + 1;
            end
            S_ACT, S_SLP: begin
               if (m_pd) m_st <= S_DS;
               else if (!hold && !btn) m_st <= S_OFF;
               else if (m_st == S_ACT && hold && !en) m_st <= S_SLP;
               else if (m_st == S_SLP && en) m_st <= S_ACT;
            end
            S_DS: if (btn) m_st <= S_WW;
            default: if (pg5) begin m_st <= S_RW; m_cnt <= 0; end
         endcase
      end
   end

   // ---------------- checking ----------------
   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (live) begin
         check(rails == m_rails, tag_of(m_st), 32'(rails), 32'(m_rails));
         check(rstn_o == m_rstn, "R3 rst_out_n", 32'(rstn_o), 32'(m_rstn));
         check(bstat_n == m_bsn, "R7 btn_stat_n", 32'(bstat_n), 32'(m_bsn));
         check(rdata == {m_keep, m_rdy, m_pd}, "R10 reg_rdata", 32'(rdata),
               32'({m_keep, m_rdy, m_pd}));
      end
   end

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 5000) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=<5000", cyc);
         finish_run();
      end
   end

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] v);
      @(negedge clk); we = 1'b1; wd = v;
      @(negedge clk); we = 1'b0;
   endtask

   initial begin
      step(4);
      // R1 reset state
      check(rails == 7'h00 && rstn_o == 0 && bstat_n == 1 && rdata == 0, "R1 reset",
            {rails, rstn_o, bstat_n, rdata}, {7'h00, 1'b0, 1'b1, 3'b000});
      rst_n = 1'b1; live = 1'b1;
      // R8: power-down write while off is ignored
      wr(3'b001);
      check(rdata[0] == 1'b0, "R8 write ignored off", 32'(rdata), 0);
      // R2 cold start
      btn = 1'b1;
      step(2);
      check(rails == 7'b0010100, "R2 first rails", 32'(rails), 32'h14);
      step(4);
      check(rails == 7'b0010100, "R2 wait pg", 32'(rails), 32'h14);
      pg5 = 1'b1;
      step(3);
      check(rails == 7'b0010100, "R2 stagger", 32'(rails), 32'h14);
      step(1);
      check(rails == 7'b0010111, "R3 early rails", 32'(rails), 32'h17);
      step(5);
      check(rstn_o == 1'b0, "R3 reset still low", 32'(rstn_o), 0);
      step(1);
      check(rstn_o == 1'b1, "R3 reset released", 32'(rstn_o), 1);
      check(bstat_n == 1'b0, "R7 press while running", 32'(bstat_n), 0);
      // R4 release with hold low
      btn = 1'b0;
      step(2);
      check(rails == 7'h00 && rstn_o == 0, "R4 shutdown", 32'(rails), 0);
      // second cold start with hold and enable
      hold = 1'b1; en = 1'b1; btn = 1'b1;
      step(20);
      btn = 1'b0;
      step(2);
      check(rails == 7'h7F, "R5 all rails", 32'(rails), 32'h7F);
      // R5 light sleep
      en = 1'b0;
      step(2);
      check(rails == 7'b0010011, "R5 sleep rails", 32'(rails), 32'h13);
      btn = 1'b1;
      step(1);
      check(bstat_n == 1'b0, "R7 press in sleep", 32'(bstat_n), 0);
      btn = 1'b0;
      step(1);
      check(bstat_n == 1'b1, "R7 release", 32'(bstat_n), 1);
      // R6 keep rail 3
      wr(3'b100);
      step(1);
      check(rails == 7'b0010111, "R6 rail3 kept", 32'(rails), 32'h17);
      // R10 ready flag, R8 deep sleep
      wr(3'b110);
      pg5 = 1'b0;
      wr(3'b111);
      step(2);
      check(rails == 7'b0000001 && rstn_o == 0, "R8 deep rails", 32'(rails), 1);
      check(rdata == 3'b111, "R10 flags in deep", 32'(rdata), 7);
      // R11 same-cycle press and power-down write
      @(negedge clk); btn = 1'b1; we = 1'b1; wd = 3'b011;
      @(negedge clk); btn = 1'b0; we = 1'b0;
      check(rdata == 3'b010, "R11 button wins", 32'(rdata), 2);
      step(1);
      check(rails == 7'b0010101, "R9 wake rails", 32'(rails), 32'h15);
      step(3);
      check(rails == 7'b0010101, "R9 wait pg", 32'(rails), 32'h15);
      pg5 = 1'b1;
      step(2);
      check(rails == 7'b0010111, "R9 no stagger", 32'(rails), 32'h17);
      step(RST + 1);
      check(rstn_o == 1'b1, "R9 reset released", 32'(rstn_o), 1);
      check(rdata[1] == 1'b1, "R10 ready survives wake", 32'(rdata), 2);
      wr(3'b000);
      check(rdata == 3'b000, "R10 ready cleared", 32'(rdata), 0);
      step(3);
      finish_run();
   end

endmodule